// File: doc/BRIEF.md
# XGMII Transmit Frame Encapsulator

This block sits between a byte-wide client transmit stream and a single-lane XGMII-style output. Each output cycle carries one byte and one control flag. Client frames arrive with start-of-packet and end-of-packet markers under a ready/valid handshake. The block wraps each frame in a START control character, a preamble, a start-of-frame delimiter (SFD) and a terminate control character. Between frames it fills the line with idle control characters.

A configuration input picks the framing mode, and the block samples it when a frame begins. In default mode the block builds the whole preamble itself and holds the client off while it does so. In custom-preamble mode the client's first eight bytes become the preamble. The block overwrites the first of those bytes with START and the last with the SFD value, and passes the six between them unchanged. If the client lets valid fall inside a frame, the block does not stall the line. It emits an error control character for every empty cycle and goes on forwarding the frame.

Top module: `xtx_xgmii_tx_encap`

## Requirements
- R1: When no frame is in progress, and out of reset, the output is the idle control character (ctrl=1, byte 0x07).
- R2: In default mode (cfg_custom_pre=0) a frame goes out as START (ctrl=1, 0xFB), six data bytes 0x55, the data byte 0xD5, and then every client byte in order as data (ctrl=0), whatever its value.
- R3: In default mode in_ready stays low from the cycle a start-of-packet beat is offered in idle until the SFD has been emitted, which is 8 cycles. The first client byte is then accepted and not lost.
- R4: Each frame ends with the terminate control character (ctrl=1, 0xFD) on the cycle after its last byte, and idle follows.
- R5: In custom mode (cfg_custom_pre=1) the first eight client bytes form the preamble. Byte 1 is output as START (ctrl=1, 0xFB), bytes 2 to 7 are output unchanged as data, and byte 8 is output as data 0xD5. Later bytes are payload, and the client is never stalled.
- R6: In custom mode the terminate character 0xFD (ctrl=1) is still appended after the last byte.
- R7: If in_valid is low during the payload of a frame, each such cycle outputs the error control character (ctrl=1, 0xFE). The bytes that follow are forwarded intact.
- R8: The mode is taken when the frame starts. A change of cfg_custom_pre during a frame applies from the next frame.
- R9: Beats offered in idle without start-of-packet are accepted and discarded, and the output stays idle.
- R10: A one-byte frame (start and end on the same beat) in default mode gives the full preamble, the byte and the terminate character.
- R11: In custom mode, a cycle with in_valid low inside the preamble outputs the error character and does not advance the preamble position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_custom_pre | input | 1 | 1 selects custom-preamble mode, 0 default mode |
| in_valid | input | 1 | Client byte valid |
| in_ready | output | 1 | Block accepts the client byte this cycle |
| in_data | input | 8 | Client byte |
| in_sop | input | 1 | Beat is the first byte of a frame |
| in_eop | input | 1 | Beat is the last byte of a frame |
| xg_data | output | 8 | Output lane byte |
| xg_ctrl | output | 1 | Output lane control flag (1 = control character) |

## Verification
The hardest state to reach is a custom-mode frame that loses valid while it is still inside the preamble. In that state an error character must appear and the preamble position must hold, so that the SFD replacement still lands on the eighth client byte. The bench gets there by dropping valid for a set number of cycles after a chosen client byte. It compares the whole captured output stream against one built from the requirements. It also flips the mode input while the default preamble is still being emitted, to show that the running frame keeps its mode.

// File: rtl/xtx_pkg.sv
package xtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_DATA,
        ST_TERM
    } xtx_state_e;

    typedef struct packed {
        logic       ctrl;
        logic [7:0] data;
    } xtx_lane_t;

    localparam logic [7:0] CH_IDLE  = 8'h07;
    localparam logic [7:0] CH_START = 8'hFB;
    localparam logic [7:0] CH_TERM  = 8'hFD;
    localparam logic [7:0] CH_ERR   = 8'hFE;
    localparam logic [7:0] PRE_FILL = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;

    function automatic xtx_lane_t ctl_lane(input logic [7:0] c);
        ctl_lane.ctrl = 1'b1;
        ctl_lane.data = c;
    endfunction

    function automatic xtx_lane_t dat_lane(input logic [7:0] d);
        dat_lane.ctrl = 1'b0;
        dat_lane.data = d;
    endfunction

endpackage

// File: rtl/xtx_seq.sv
module xtx_seq
    import xtx_pkg::*;
#(
    parameter int unsigned PRE_BYTES = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_custom_pre,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic       in_eop,
    output xtx_state_e state,
    output logic       cust,
    output logic       start_go,
    output logic       in_ready
);
    localparam int unsigned CNT_W = (PRE_BYTES > 2) ? $clog2(PRE_BYTES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRE_BYTES - 2);

    xtx_state_e       st_q;
    logic             cust_q;
    logic [CNT_W-1:0] cnt_q;
    logic             adv;

    assign state    = st_q;
    assign cust     = cust_q;
    assign start_go = (st_q == ST_IDLE) && in_valid && in_sop;
    assign adv      = !cust_q || in_valid;

    always_comb begin
        unique case (st_q)
            ST_IDLE:         in_ready = cfg_custom_pre || !in_sop;
            ST_PRE, ST_SFD:  in_ready = cust_q;
            ST_DATA:         in_ready = 1'b1;
            default:         in_ready = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cust_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_go) begin
                        cust_q <= cfg_custom_pre;
                        cnt_q  <= '0;
                        st_q   <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    if (adv) begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q <= '0;
                            st_q  <= ST_SFD;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_SFD: begin
                    if (adv) st_q <= ST_DATA;
                end
                ST_DATA: begin
                    if (in_valid && in_eop) st_q <= ST_TERM;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xtx_lane_mux.sv
module xtx_lane_mux
    import xtx_pkg::*;
(
    input  xtx_state_e state,
    input  logic       cust,
    input  logic       start_go,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output xtx_lane_t  lane
);
    always_comb begin
        unique case (state)
            ST_IDLE:
                lane = start_go ? ctl_lane(CH_START) : ctl_lane(CH_IDLE);
            ST_PRE: begin
                if (!cust)        lane = dat_lane(PRE_FILL);
                else if (in_valid) lane = dat_lane(in_data);
                else              lane = ctl_lane(CH_ERR);
            end
            ST_SFD:
                lane = (cust && !in_valid) ? ctl_lane(CH_ERR) : dat_lane(SFD_BYTE);
            ST_DATA:
                lane = in_valid ? dat_lane(in_data) : ctl_lane(CH_ERR);
            default:
                lane = ctl_lane(CH_TERM);
        endcase
    end

endmodule

// File: rtl/xtx_xgmii_tx_encap.sv
module xtx_xgmii_tx_encap
    import xtx_pkg::*;
#(
    parameter int unsigned PRE_BYTES = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_custom_pre,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_sop,
    input  logic       in_eop,
    output logic [7:0] xg_data,
    output logic       xg_ctrl
);
    xtx_state_e st_w;
    logic       cust_w;
    logic       start_w;
    xtx_lane_t  lane_d;
    xtx_lane_t  lane_q;

    xtx_seq #(.PRE_BYTES(PRE_BYTES)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .cfg_custom_pre (cfg_custom_pre),
        .in_valid       (in_valid),
        .in_sop         (in_sop),
        .in_eop         (in_eop),
        .state          (st_w),
        .cust           (cust_w),
        .start_go       (start_w),
        .in_ready       (in_ready)
    );

    xtx_lane_mux u_mux (
        .state    (st_w),
        .cust     (cust_w),
        .start_go (start_w),
        .in_valid (in_valid),
        .in_data  (in_data),
        .lane     (lane_d)
    );

    always_ff @(posedge clk) begin
        if (rst) lane_q <= ctl_lane(CH_IDLE);
        else     lane_q <= lane_d;
    end

    assign xg_data = lane_q.data;
    assign xg_ctrl = lane_q.ctrl;

endmodule

// File: rtl/xtx_encap_chk.sv
module xtx_encap_chk
    import xtx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input xtx_state_e state,
    input logic       cust,
    input logic       in_valid,
    input logic       in_sop,
    input logic       in_eop,
    input logic       in_ready,
    input logic [7:0] xg_data,
    input logic       xg_ctrl
);
    p_idle_fill_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !(in_valid && in_sop)) |=> (xg_ctrl && xg_data == CH_IDLE));

    p_start_prev_r2: assert property (@(posedge clk) disable iff (rst)
        (xg_ctrl && xg_data == CH_START) |->
            ($past(xg_ctrl) && ($past(xg_data) == CH_IDLE || $past(xg_data) == CH_TERM)));

    p_sfd_slot_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SFD && (!cust || in_valid)) |=> (!xg_ctrl && xg_data == SFD_BYTE));

    p_ready_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_PRE || state == ST_SFD || state == ST_TERM) && !cust) |-> !in_ready);

    p_term_after_last_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && in_valid && in_eop) |=> ##1 (xg_ctrl && xg_data == CH_TERM));

    p_err_on_gap_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && !in_valid) |=> (xg_ctrl && xg_data == CH_ERR));

    p_mode_locked_r8: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(cust));

endmodule

bind xtx_xgmii_tx_encap xtx_encap_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .state    (st_w),
    .cust     (cust_w),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .in_eop   (in_eop),
    .in_ready (in_ready),
    .xg_data  (xg_data),
    .xg_ctrl  (xg_ctrl)
);

// File: tb/xtx_xgmii_tx_encap_tb_top.sv
module xtx_xgmii_tx_encap_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [8:0] L_IDLE  = {1'b1, 8'h07};
    localparam logic [8:0] L_START = {1'b1, 8'hFB};
    localparam logic [8:0] L_TERM  = {1'b1, 8'hFD};
    localparam logic [8:0] L_ERR   = {1'b1, 8'hFE};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_custom_pre = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_sop = 1'b0;
    logic       in_eop = 1'b0;
    logic [7:0] xg_data;
    logic       xg_ctrl;

    int checks = 0;
    int fails  = 0;
    logic [8:0] cap[$];
    logic [8:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xtx_xgmii_tx_encap dut_i (
        .clk(clk), .rst(rst), .cfg_custom_pre(cfg_custom_pre),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .xg_data(xg_data), .xg_ctrl(xg_ctrl)
    );

    always @(posedge clk) begin
        #1;
        if (!rst) cap.push_back({xg_ctrl, xg_data});
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic build_exp(input bit cust, input logic [7:0] fr[$],
                             input int gap_at, input int gap_n);
        exp_q.delete();
        exp_q.push_back(L_START);
        if (!cust) begin
            for (int k = 0; k < 6; k++) exp_q.push_back({1'b0, 8'h55});
            exp_q.push_back({1'b0, 8'hD5});
        end
        for (int i = 0; i < fr.size(); i++) begin
            if (cust && i == 7)     exp_q.push_back({1'b0, 8'hD5});
            else if (!cust || i > 0) exp_q.push_back({1'b0, fr[i]});
            if (i == gap_at)
                for (int g = 0; g < gap_n; g++) exp_q.push_back(L_ERR);
        end
        exp_q.push_back(L_TERM);
    endtask

    task automatic send_frame(input logic [7:0] fr[$], input int gap_at,
                              input int gap_n, output int stalls);
        logic rdy;
        stalls = 0;
        for (int i = 0; i < fr.size(); i++) begin
            in_valid = 1'b1;
            in_data  = fr[i];
            in_sop   = (i == 0);
            in_eop   = (i == fr.size() - 1);
            forever begin
                #1 rdy = in_ready;
                @(posedge clk);
                if (rdy) break;
                stalls++;
                @(negedge clk);
            end
            @(negedge clk);
            in_valid = 1'b0;
            in_sop   = 1'b0;
            in_eop   = 1'b0;
            if (i == gap_at) repeat (gap_n) @(negedge clk);
        end
    endtask

    task automatic compare_stream(input string req);
        while (cap.size() > 0 && cap[0] == L_IDLE) void'(cap.pop_front());
        while (cap.size() > 0 && cap[cap.size()-1] == L_IDLE) void'(cap.pop_back());
        check({req, " length"}, cap.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < cap.size(); i++)
            check(req, {23'd0, cap[i]}, {23'd0, exp_q[i]});
    endtask

    task automatic run_frame(input string req, input bit cust, input logic [7:0] fr[$],
                             input int gap_at, input int gap_n, input int exp_stalls);
        int st;
        cap.delete();
        build_exp(cust, fr, gap_at, gap_n);
        send_frame(fr, gap_at, gap_n, st);
        repeat (6) @(negedge clk);
        compare_stream(req);
        if (exp_stalls >= 0) check({req, " stalls"}, st, exp_stalls);
    endtask

    task automatic t_reset_idle();
        repeat (3) @(negedge clk);
        check("R1 idle ctrl", {31'd0, xg_ctrl}, 1);
        check("R1 idle byte", {24'd0, xg_data}, 32'h07);
    endtask

    task automatic t_default_frame();
        logic [7:0] fr[$] = '{8'hFB, 8'hFD, 8'h07, 8'h55, 8'h12};
        cfg_custom_pre = 1'b0;
        run_frame("R2 R3 R4 default", 1'b0, fr, -1, 0, 8);
    endtask

    task automatic t_single_byte();
        logic [7:0] fr[$] = '{8'h3C};
        cfg_custom_pre = 1'b0;
        run_frame("R10 one-byte", 1'b0, fr, -1, 0, 8);
    endtask

    task automatic t_custom_frame();
        logic [7:0] fr[$];
        for (int i = 0; i < 12; i++) fr.push_back(8'hA0 + 8'(i));
        cfg_custom_pre = 1'b1;
        run_frame("R5 R6 custom", 1'b1, fr, -1, 0, 0);
    endtask

    task automatic t_payload_gap();
        logic [7:0] fr[$] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
        cfg_custom_pre = 1'b0;
        run_frame("R7 payload gap", 1'b0, fr, 2, 3, 8);
    endtask

    task automatic t_custom_pre_gap();
        logic [7:0] fr[$];
        for (int i = 0; i < 10; i++) fr.push_back(8'h30 + 8'(i));
        cfg_custom_pre = 1'b1;
        run_frame("R11 preamble gap", 1'b1, fr, 3, 2, 0);
    endtask

    task automatic t_mode_flip();
        logic [7:0] fr[$] = '{8'hC1, 8'hC2, 8'hC3};
        logic [7:0] fr2[$];
        for (int i = 0; i < 9; i++) fr2.push_back(8'h60 + 8'(i));
        cfg_custom_pre = 1'b0;
        fork
            run_frame("R8 flip keeps default", 1'b0, fr, -1, 0, 8);
            begin
                repeat (3) @(negedge clk);
                cfg_custom_pre = 1'b1;
            end
        join
        run_frame("R8 next frame custom", 1'b1, fr2, -1, 0, 0);
    endtask

    task automatic t_stray_beats();
        logic rdy;
        int taken = 0;
        cfg_custom_pre = 1'b0;
        cap.delete();
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1;
            in_data  = 8'hE0 + 8'(i);
            in_sop   = 1'b0;
            in_eop   = (i == 3);
            #1 rdy = in_ready;
            if (rdy) taken++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_eop   = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 stray beats accepted", taken, 4);
        exp_q.delete();
        compare_stream("R9 output stays idle");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_idle();
        t_default_frame();
        t_single_byte();
        t_custom_frame();
        t_payload_gap();
        t_custom_pre_gap();
        t_mode_flip();
        t_stray_beats();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule